// File: doc/BRIEF.md
# Memory Bit Read-Modify-Write Sequencer

This block performs one single-bit operation on a byte held in memory. A command names the operation, a bit number within the byte, a 32-bit base value and a signed 16-bit displacement. The block adds the sign-extended displacement to the base to form the byte address. It reads that byte over a request/acknowledge memory port and sets the zero flag from the selected bit as it was read. It then writes the byte back with that one bit set, inverted or cleared. The test operation only updates the flag and performs no write.

Commands arrive on a valid/ready port. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high, and its fields are sampled only on that cycle. `cmd_ready` is high only while the sequencer is idle, so a request made while an operation is in flight is not taken and leaves no trace. On the memory side the block raises `mem_req` and holds the address, direction and write data steady until the memory answers with `mem_ack`. The memory may stall for any number of cycles. `done` pulses once when the operation has finished.

Top module: `bitop_rmw_unit`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, and `mem_req`, `done` and `zf` are all 0.
- R2: A command is accepted only when `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while idle. A `cmd_valid` asserted while busy has no effect on memory or on the flag.
- R3: The memory address is `cmd_base` plus `cmd_disp` sign-extended to 32 bits, with modulo 2^32 wraparound. It stays constant while `mem_req` is high.
- R4: The first access of every operation is a read (`mem_we` = 0). `mem_req`, `mem_we` and the address are held until `mem_ack` arrives, for any number of wait cycles.
- R5: On the cycle after the read is acknowledged, `zf` is 1 if bit `cmd_bit` of the byte read was 0, and 0 otherwise. Bit number 0 is the least significant bit. `zf` keeps its value at all other times.
- R6: Operation codes on `cmd_op` are 2'b00 set, 2'b01 invert and 2'b10 clear. For these codes a write (`mem_we` = 1) to the same address follows the read. It carries the byte read with only the selected bit changed, and the write data is held until acknowledged.
- R7: Operation code 2'b11 (test) never raises `mem_we` and leaves the byte in memory unchanged.
- R8: `done` is high for exactly one cycle. That cycle follows the final acknowledge, which is the read acknowledge for test and the write acknowledge otherwise. `cmd_ready` returns high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | Operation: 00 set, 01 invert, 10 clear, 11 test |
| cmd_bit | input | 3 | Bit number within the byte |
| cmd_base | input | 32 | Base address value |
| cmd_disp | input | 16 | Signed displacement |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, valid with `mem_ack` on a read |
| mem_ack | input | 1 | Memory access completed this cycle |
| zf | output | 1 | Zero flag from the last read bit |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the memory raises `mem_ack` only while `mem_req` is high. They also assume that `mem_ack` lasts a single cycle and that `mem_rdata` is valid in that cycle. The bench memory model follows these rules. It answers each request after a random wait of zero to three cycles and drops `mem_ack` after one cycle. It writes or returns a byte only in that acknowledge cycle. Command fields may change freely while `cmd_ready` is low. The bench does this deliberately, keeping `cmd_valid` high with a different target during a busy cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    OP_SET = 2'b00,
    OP_INV = 2'b01,
    OP_CLR = 2'b10,
    OP_TST = 2'b11
  } bitop_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/bitop_agen.sv
module bitop_agen #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] addr_q;

  // sign extension of the displacement to the address width
  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= base + disp_ext;
    end
  end

  assign addr = addr_q;
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [BIT_W-1:0]  bitsel,
  input  bitop_e            op,
  output logic [DATA_W-1:0] dout,
  output logic              bit_was_zero
);
  // one lane per bit; only the selected lane is altered
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    logic hit;
    assign hit = (bitsel == BIT_W'(i));
    always_comb begin
      dout[i] = din[i];
      if (hit) begin
        unique case (op)
          OP_SET:  dout[i] = 1'b1;
          OP_INV:  dout[i] = ~din[i];
          OP_CLR:  dout[i] = 1'b0;
          default: dout[i] = din[i];
        endcase
      end
    end
  end

  assign bit_was_zero = ~din[bitsel];
endmodule

// File: rtl/bitop_seq.sv
module bitop_seq
  import bitop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic is_test,
  input  logic mem_ack,
  output logic cmd_ready,
  output logic accept,
  output logic rd_ack,
  output logic mem_req,
  output logic mem_we,
  output logic done
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (cmd_valid) state_d = ST_READ;
      ST_READ:  if (mem_ack)   state_d = is_test ? ST_DONE : ST_WRITE;
      ST_WRITE: if (mem_ack)   state_d = ST_DONE;
      ST_DONE:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_ready && cmd_valid;
  assign rd_ack    = (state_q == ST_READ) && mem_ack;
  assign mem_req   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/bitop_rmw_unit.sv
module bitop_rmw_unit
  import bitop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int DATA_W = 8,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [BIT_W-1:0]  cmd_bit,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [DISP_W-1:0] cmd_disp,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              zf,
  output logic              done
);
  logic              accept;
  logic              rd_ack;
  bitop_e            op_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] byte_q;
  logic [DATA_W-1:0] mod_byte;
  logic              bit_zero;
  logic              zf_q;

  bitop_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .is_test   (op_q == OP_TST),
    .mem_ack   (mem_ack),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .rd_ack    (rd_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .done      (done)
  );

  bitop_agen #(
    .ADDR_W (ADDR_W),
    .DISP_W (DISP_W)
  ) u_agen (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .base  (cmd_base),
    .disp  (cmd_disp),
    .addr  (mem_addr)
  );

  bitop_alu #(
    .DATA_W (DATA_W),
    .BIT_W  (BIT_W)
  ) u_alu (
    .din          (mem_rdata),
    .bitsel       (bit_q),
    .op           (op_q),
    .dout         (mod_byte),
    .bit_was_zero (bit_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_SET;
      bit_q  <= '0;
      byte_q <= '0;
      zf_q   <= 1'b0;
    end else begin
      if (accept) begin
        op_q  <= bitop_e'(cmd_op);
        bit_q <= cmd_bit;
      end
      if (rd_ack) begin
        byte_q <= mod_byte;
        zf_q   <= bit_zero;
      end
    end
  end

  assign mem_wdata = byte_q;
  assign zf        = zf_q;
endmodule

// File: rtl/bitop_rmw_unit_chk.sv
module bitop_rmw_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic              zf,
  input logic              done
);
  logic [1:0] op_seen;

  always_ff @(posedge clk) begin
    if (!rst_n)                      op_seen <= 2'b00;
    else if (cmd_valid && cmd_ready) op_seen <= cmd_op;
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!mem_req && !done)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R3
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> $stable(mem_we)); // R4
  AST_FIRST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (mem_req && !mem_we)); // R4
  AST_ZF_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && !mem_we && mem_ack) |=> $stable(zf)); // R5
  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata)); // R6
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (op_seen != 2'b11)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready)); // R8
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> done); // R8
endmodule

bind bitop_rmw_unit bitop_rmw_unit_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .zf        (zf),
  .done      (done)
);

// File: tb/bitop_rmw_unit_bench.sv
module bitop_rmw_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [2:0]  cmd_bit = 3'd0;
  logic [31:0] cmd_base = 32'h0;
  logic [15:0] cmd_disp = 16'h0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;
  logic        mem_ack = 1'b0;
  logic        zf, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int writes = 0;
  int lat = 0;
  logic [7:0] mem [int unsigned];

  // reference model state
  int          m_ph = 0;     // 0 idle, 1 read, 2 write, 3 done
  logic [31:0] m_addr = 32'h0;
  logic [1:0]  m_op = 2'b00;
  logic [2:0]  m_bit = 3'd0;
  logic [7:0]  m_new = 8'h00;
  logic        m_zf = 1'b0;

  always #10 clk = ~clk;

  bitop_rmw_unit u_bitop_rmw_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_bit(cmd_bit), .cmd_base(cmd_base), .cmd_disp(cmd_disp),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .zf(zf), .done(done)
  );

  function automatic logic [7:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic wrap_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_ph <= 0;
      m_zf <= 1'b0;
    end else begin
      case (m_ph)
        0: if (cmd_valid) begin
             m_addr <= cmd_base + {{16{cmd_disp[15]}}, cmd_disp};
             m_op   <= cmd_op;
             m_bit  <= cmd_bit;
             m_ph   <= 1;
           end
        1: if (mem_ack) begin
             m_zf <= !mem_rdata[m_bit];
             case (m_op)
               2'b00:   m_new <= mem_rdata | (8'h01 << m_bit);
               2'b01:   m_new <= mem_rdata ^ (8'h01 << m_bit);
               2'b10:   m_new <= mem_rdata & ~(8'h01 << m_bit);
               default: m_new <= mem_rdata;
             endcase
             m_ph <= (m_op == 2'b11) ? 3 : 2;
           end
        2: if (mem_ack) m_ph <= 3;
        default: m_ph <= 0;
      endcase
    end
  end

  // per-cycle comparison and memory responder, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(cmd_ready == (m_ph == 0), "R2 cmd_ready", 32'(cmd_ready), 32'(m_ph == 0));
      chk(mem_req == (m_ph == 1 || m_ph == 2), "R4 mem_req", 32'(mem_req), 32'(m_ph == 1 || m_ph == 2));
      chk(mem_we == (m_ph == 2), "R7 mem_we", 32'(mem_we), 32'(m_ph == 2));
      if (mem_req) chk(mem_addr == m_addr, "R3 mem_addr", mem_addr, m_addr);
      if (m_ph == 2) chk(mem_wdata == m_new, "R6 mem_wdata", 32'(mem_wdata), 32'(m_new));
      chk(done == (m_ph == 3), "R8 done", 32'(done), 32'(m_ph == 3));
      chk(zf == m_zf, "R5 zf", 32'(zf), 32'(m_zf));
    end
    if (mem_ack) begin
      mem_ack <= 1'b0;
      lat = int'($urandom_range(0, 3));
    end else if (mem_req) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          writes++;
        end else begin
          mem_rdata <= rd(mem_addr);
        end
      end else begin
        lat--;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
      wrap_up();
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [2:0] b,
                        input logic [31:0] base, input logic [15:0] disp, input bit extra);
    while (!cmd_ready) @(negedge clk);
    cmd_op = op; cmd_bit = b; cmd_base = base; cmd_disp = disp;
    cmd_valid = 1'b1;
    @(negedge clk);
    if (extra) begin
      cmd_op = 2'b00; cmd_bit = 3'd4; cmd_base = 32'h0000_3000; cmd_disp = 16'h0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int w0;
    mem[32'h100]  = 8'hA5;
    mem[32'h1FFF] = 8'h00;
    mem[32'h2000] = 8'h5A;
    mem[32'h3000] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1 ready", 32'(cmd_ready), 1);
    chk(mem_req == 1'b0, "R1 req", 32'(mem_req), 0);
    chk(done == 1'b0, "R1 done", 32'(done), 0);
    chk(zf == 1'b0, "R1 zf", 32'(zf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(2'b00, 3'd1, 32'h100, 16'h0, 1'b0);          // R6 set, bit was 0
    chk(rd(32'h100) == 8'hA7, "R6 set", 32'(rd(32'h100)), 32'hA7);
    chk(zf == 1'b1, "R5 zf set", 32'(zf), 1);
    run_op(2'b00, 3'd0, 32'h100, 16'h0, 1'b0);          // bit already 1
    chk(rd(32'h100) == 8'hA7, "R6 set again", 32'(rd(32'h100)), 32'hA7);
    chk(zf == 1'b0, "R5 zf one", 32'(zf), 0);
    run_op(2'b01, 3'd7, 32'h100, 16'h0, 1'b0);          // invert msb
    chk(rd(32'h100) == 8'h27, "R6 invert", 32'(rd(32'h100)), 32'h27);
    run_op(2'b10, 3'd2, 32'h100, 16'h0, 1'b0);          // clear a one
    chk(rd(32'h100) == 8'h23, "R6 clear", 32'(rd(32'h100)), 32'h23);
    chk(zf == 1'b0, "R5 zf clear", 32'(zf), 0);
    run_op(2'b10, 3'd3, 32'h100, 16'h0, 1'b0);          // clear a zero
    chk(zf == 1'b1, "R5 zf clear zero", 32'(zf), 1);
    w0 = writes;
    run_op(2'b11, 3'd6, 32'h100, 16'h0, 1'b0);          // R7 test
    chk(writes == w0, "R7 no write", 32'(writes), 32'(w0));
    chk(rd(32'h100) == 8'h23, "R7 unchanged", 32'(rd(32'h100)), 32'h23);
    chk(zf == 1'b1, "R7 test zf", 32'(zf), 1);
    run_op(2'b00, 3'd7, 32'h2000, 16'hFFFF, 1'b0);      // R3 negative displacement
    chk(rd(32'h1FFF) == 8'h80, "R3 negative disp", 32'(rd(32'h1FFF)), 32'h80);
    chk(rd(32'h2000) == 8'h5A, "R3 base untouched", 32'(rd(32'h2000)), 32'h5A);
    run_op(2'b00, 3'd5, 32'h10, 16'h7FFF, 1'b0);        // largest positive
    chk(rd(32'h800F) == 8'h20, "R3 max disp", 32'(rd(32'h800F)), 32'h20);
    run_op(2'b01, 3'd0, 32'hFFFF_FFF0, 16'h0020, 1'b0); // wraparound
    chk(rd(32'h10) == 8'h01, "R3 wrap", 32'(rd(32'h10)), 32'h01);
    run_op(2'b11, 3'd4, 32'h100, 16'h0, 1'b1);          // R2 busy request ignored
    chk(rd(32'h3000) == 8'h00, "R2 busy ignored", 32'(rd(32'h3000)), 32'h00);
    chk(zf == 1'b1, "R2 zf from first op", 32'(zf), 1);

    for (int i = 0; i < 60; i++) begin
      run_op(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
             32'h400 + 32'($urandom_range(0, 7)), 16'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    repeat (4) @(negedge clk);
    wrap_up();
  end
endmodule